// File: doc/BRIEF.md
# External Interrupt Pin Trigger and Request Flags

This block turns a set of asynchronous, active-low external interrupt pins into request flags for an interrupt controller. Every channel brings its pin through a short synchronizer. A trigger-mode bit, set by software, selects how the synchronized pin is read. In falling-edge mode a high-to-low transition sets the channel's request flag, and the flag stays set until the CPU acknowledges that channel or software clears it. In level mode the flag tracks the pin: it is high while the pin is low.

The trigger-mode bits and the request flags together form the low part of one control register, which a simple register bus can read and write. Each channel occupies a pair of bits. The even bit of the pair is the trigger mode and the odd bit is the request flag. The flags are also brought out directly as request lines for the priority logic. Arbitration, timer control bits and the CPU sit outside this block.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every trigger-mode bit and every request flag is 0, and rd_data reads 0.
- R2: In rd_data, bit 2c is the trigger mode of channel c and bit 2c+1 is its request flag (channel 0 uses bits 0 and 1, channel 1 uses bits 2 and 3). Bits above 2*N_CH-1 read 0, and writes to them have no effect. irq_req[c] equals the flag of channel c.
- R3: With trigger mode 1 (falling edge), a 1-to-0 change on pin_n[c] sets flag c. The flag is seen at the third rising clock edge after the pin changes: two synchronizer stages plus one detection stage.
- R4: In falling-edge mode, a pin that stays low does not set the flag again after it is cleared, and a 0-to-1 change never sets the flag.
- R5: In falling-edge mode, ack[c] clears flag c at the next clock edge, as long as no write and no new edge fall in the same cycle.
- R6: With trigger mode 0 (level), flag c is the inverse of pin_n[c] delayed by three clock edges. ack[c] has no effect on it, so the flag stays high while the pin stays low.
- R7: In falling-edge mode, if a detected edge and ack[c] fall in the same cycle, the flag is set.
- R8: A register write (wr_en high) loads every trigger-mode bit. It also loads the flag bits of channels in falling-edge mode. A channel that is in level mode before the write ignores the written flag bit.
- R9: In falling-edge mode, a write and ack[c] in the same cycle with no edge detected give the written flag value.
- R10: The channels are independent: the pin, ack and mode of one channel never change the flag of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_n | input | N_CH | Asynchronous external interrupt pins, active low |
| ack | input | N_CH | Per-channel acknowledge from the CPU |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | DW | Control register write data |
| rd_data | output | DW | Control register contents |
| irq_req | output | N_CH | Request flags to the interrupt controller |

## Verification
The pins are driven with single falling edges, rising edges, long low holds and pseudo-random toggling, in both trigger modes. Holding a pin low after an acknowledge separates edge detection from level following. Timing the acknowledge and register writes so they land in the same cycle as a detected edge exposes the priority order between set, write and clear. Driving the two channels in different modes at the same time shows whether a bit lands in the wrong position or one channel leaks into the other. The exact cycle at which each flag appears is compared on every clock against a reference model built from pin history queues.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_mode_e;

  function automatic int mode_bit(input int ch);
    return 2 * ch;
  endfunction

  function automatic int flag_bit(input int ch);
    return 2 * ch + 1;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '1;
    else     stage_q[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '1;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_chan.sv
module irq_chan
  import ext_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic ack,
  input  logic wr_en,
  input  logic wr_mode,
  input  logic wr_flag,
  output logic mode_o,
  output logic flag_o
);
  trig_mode_e mode_q;
  logic       prev_q;
  logic       flag_q;
  logic       edge_hit;

  assign edge_hit = prev_q & ~pin_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      mode_q <= TRIG_LEVEL;
    end else begin
      prev_q <= pin_s;
      if (wr_en) mode_q <= trig_mode_e'(wr_mode);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (mode_q == TRIG_LEVEL) begin
      flag_q <= ~pin_s;
    end else if (edge_hit) begin
      flag_q <= 1'b1;
    end else if (wr_en) begin
      flag_q <= wr_flag;
    end else if (ack) begin
      flag_q <= 1'b0;
    end
  end

  assign mode_o = mode_q;
  assign flag_o = flag_q;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!flag_q && mode_q == TRIG_LEVEL));
  // R3
  a_r3_edge_sets: assert property (@(posedge clk) disable iff (rst)
    (mode_q == TRIG_FALL && edge_hit) |=> flag_q);
  // R5
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (mode_q == TRIG_FALL && ack && !edge_hit && !wr_en) |=> !flag_q);
  // R7
  a_r7_set_over_ack: assert property (@(posedge clk) disable iff (rst)
    (mode_q == TRIG_FALL && ack && edge_hit) |=> flag_q);
  // R9
  a_r9_write_over_ack: assert property (@(posedge clk) disable iff (rst)
    (mode_q == TRIG_FALL && ack && wr_en && !edge_hit) |=> (flag_q == $past(wr_flag)));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int N_CH        = 2,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] pin_n,
  input  logic [N_CH-1:0] ack,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  output logic [N_CH-1:0] irq_req
);
  localparam int NIB = 2 * N_CH;

  logic [N_CH-1:0] pin_s;
  logic [N_CH-1:0] mode_v;
  logic [N_CH-1:0] flag_v;
  logic [NIB-1:0]  ctrl_v;

  irq_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (pin_n),
    .d_out (pin_s)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    irq_chan u_chan (
      .clk     (clk),
      .rst     (rst),
      .pin_s   (pin_s[c]),
      .ack     (ack[c]),
      .wr_en   (wr_en),
      .wr_mode (wr_data[mode_bit(c)]),
      .wr_flag (wr_data[flag_bit(c)]),
      .mode_o  (mode_v[c]),
      .flag_o  (flag_v[c])
    );
    assign ctrl_v[mode_bit(c)] = mode_v[c];
    assign ctrl_v[flag_bit(c)] = flag_v[c];
  end

  if (DW > NIB) begin : g_pad
    assign rd_data = {{(DW-NIB){1'b0}}, ctrl_v};
  end else begin : g_nopad
    assign rd_data = ctrl_v[DW-1:0];
  end

  assign irq_req = flag_v;

  // Cycles since reset, saturating; used only to keep the delay check clear of reset.
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)              age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    // R6
    a_r6_level_tracks_pin: assert property (@(posedge clk) disable iff (rst)
      (age_q == 2'd3 && !$past(mode_v[c])) |-> (irq_req[c] == !$past(pin_n[c], 3)));
  end

  // R2
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data >> NIB) == '0);
endmodule

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
  localparam int PERIOD = 10;
  localparam int N_CH   = 2;
  localparam int DW     = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N_CH-1:0] pin_n = '1;
  logic [N_CH-1:0] ack = '0;
  logic            wr_en = 1'b0;
  logic [DW-1:0]   wr_data = '0;
  logic [DW-1:0]   rd_data;
  logic [N_CH-1:0] irq_req;

  int    checks = 0;
  int    failures = 0;
  string tag = "R1";
  bit    armed = 0;
  bit    done = 0;

  // reference model state
  bit  m_mode [N_CH];
  bit  m_flag [N_CH];
  bit  hist [N_CH][$];

  always #(PERIOD/2) clk = ~clk;

  ext_irq_ctrl #(.N_CH(N_CH), .DW(DW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .pin_n(pin_n), .ack(ack),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_req(irq_req)
  );

  // Behavioural model: hist[c][0] is the pin seen one edge ago, [1] two, [2] three.
  always @(posedge clk) begin
    for (int c = 0; c < N_CH; c++) begin
      if (rst) begin
        m_mode[c] = 0;
        m_flag[c] = 0;
        hist[c] = '{1, 1, 1};
      end else begin
        if (!m_mode[c]) m_flag[c] = !hist[c][1];
        else if (hist[c][2] && !hist[c][1]) m_flag[c] = 1;
        else if (wr_en) m_flag[c] = wr_data[2*c+1];
        else if (ack[c]) m_flag[c] = 0;
        if (wr_en) m_mode[c] = wr_data[2*c];
        hist[c].push_front(pin_n[c]);
        void'(hist[c].pop_back());
      end
    end
  end

  function automatic logic [DW-1:0] model_word();
    logic [DW-1:0] w = '0;
    for (int c = 0; c < N_CH; c++) begin
      w[2*c]   = m_mode[c];
      w[2*c+1] = m_flag[c];
    end
    return w;
  endfunction

  task automatic compare();
    logic [DW-1:0]   exp_w = model_word();
    logic [N_CH-1:0] exp_q;
    for (int c = 0; c < N_CH; c++) exp_q[c] = m_flag[c];
    checks++;
    if (rd_data !== exp_w) begin
      failures++;
      $display("FAIL %s rd_data actual=%h expected=%h at %0t", tag, rd_data, exp_w, $time);
    end
    checks++;
    if (irq_req !== exp_q) begin
      failures++;
      $display("FAIL %s irq_req actual=%b expected=%b at %0t", tag, irq_req, exp_q, $time);
    end
  endtask

  always @(negedge clk) if (armed) compare();

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_data = d; cyc(); wr_en = 1'b0;
  endtask

  task automatic expect_flag(input int c, input bit v, input string req);
    checks++;
    if (irq_req[c] !== v) begin
      failures++;
      $display("FAIL %s ch%0d flag actual=%b expected=%b", req, c, irq_req[c], v);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    cyc(3);
    armed = 1;                      // R1: reset state compared on every clock
    rst = 1'b0;
    cyc(2);
    expect_flag(0, 0, "R1");

    tag = "R2";                     // edge mode on both, upper bits ignored
    wr(8'hF5);
    cyc(2);
    tag = "R3";
    pin_n[0] = 1'b0;
    cyc(2);
    expect_flag(0, 0, "R3");        // two edges: not yet
    cyc(1);
    expect_flag(0, 1, "R3");        // third edge: set
    expect_flag(1, 0, "R10");
    cyc(3);

    tag = "R5";
    ack[0] = 1'b1; cyc(); ack[0] = 1'b0;
    expect_flag(0, 0, "R5");

    tag = "R4";                     // held low, then a rising edge: no set
    cyc(6);
    expect_flag(0, 0, "R4");
    pin_n[0] = 1'b1;
    cyc(6);
    expect_flag(0, 0, "R4");

    tag = "R7";                     // ack held across the edge
    ack[0] = 1'b1;
    pin_n[0] = 1'b0;
    cyc(3);
    expect_flag(0, 1, "R7");
    cyc(2);
    ack[0] = 1'b0;
    pin_n[0] = 1'b1;
    cyc(4);

    tag = "R9";                     // write flag1=1 with ack1 in same cycle
    ack[1] = 1'b1;
    wr(8'h0D);
    ack[1] = 1'b0;
    expect_flag(1, 1, "R9");
    tag = "R8";
    wr(8'h05);
    expect_flag(1, 0, "R8");
    wr(8'h04);                      // channel 0 to level mode
    cyc(2);
    wr(8'h06);                      // flag0 write ignored in level mode
    expect_flag(0, 0, "R8");
    cyc(2);

    tag = "R6";
    pin_n[0] = 1'b0;
    cyc(3);
    expect_flag(0, 1, "R6");
    ack[0] = 1'b1; cyc(4); ack[0] = 1'b0;
    expect_flag(0, 1, "R6");
    pin_n[0] = 1'b1;
    cyc(3);
    expect_flag(0, 0, "R6");

    tag = "R10";                    // mixed modes, pseudo-random stimulus
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pin_n   = lfsr[1:0];
      ack     = lfsr[5:4] & {2{lfsr[7]}};
      wr_en   = (lfsr[11:9] == 3'b101);
      wr_data = {lfsr[3:0], lfsr[15:12]};
      cyc();
    end
    wr_en = 1'b0;
    ack = '0;
    pin_n = '1;
    cyc(5);

    tag = "R1";
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    expect_flag(0, 0, "R1");
    expect_flag(1, 0, "R1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule